// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a stream of received Ethernet bytes, each beat carrying a start-of-frame and an end-of-frame marker, and stores it in a ring of fixed 128-byte receive buffers. It emits one buffer byte write for every byte it accepts. Each time it finishes with a buffer, it emits one 64-bit descriptor write holding an address word and a control word.

A frame longer than one buffer continues in the next descriptor of the ring. The first fragment is flagged as start of frame. The final fragment is flagged as end of frame and carries the total frame length. Every buffer the block fills is claimed by setting an ownership bit. Software hands a buffer back by clearing that bit through a release port.

When the block advances onto a descriptor that software still owns, it raises a buffer-not-available flag. A byte that finds no free buffer raises an overrun flag, and the rest of that frame is discarded. Sticky status flags drive a single interrupt line.

Top module: `rx_ring_writer`

## Requirements
- R1: Each accepted frame byte is written, one cycle after it is presented, to address `(buf_base with its low 7 bits cleared) + index*128 + offset`. Here index is the current ring slot and offset is the byte's position inside that slot.
- R2: A slot closes when its 128th byte or the frame's last byte is written. In that same output cycle a descriptor write goes to `ring_base + index*8`, and the ring pointer moves to the next slot.
- R3: Closing a slot sets its ownership bit, which is bit 0 of the address word. The block never writes into a slot whose bit is set. A pulse on `rel_en` clears the bit of slot `rel_idx`. If a claim and a release hit the same slot in one cycle, the claim wins.
- R4: The address word is the slot's buffer address with bit 0 = 1 (owned) and bit 1 = 1 (wrap) only for the last slot (index RING_ENTRIES-1). After the last slot the pointer returns to slot 0.
- R5: Control word bit 14 (start flag) is set only in the first fragment of a frame. Bit 15 (end flag) is set only in its final fragment.
- R6: Control word bits [10:0] hold the total frame length modulo 2048 in the final fragment, and are zero in every other fragment.
- R7: Status bit 0 (frame done) is set when a frame's final descriptor is written.
- R8: Status bit 1 (no buffer) is set when the pointer advances onto an owned slot, or when a frame byte needs a new slot that is owned.
- R9: Status bit 2 (overrun) is set when a frame byte is discarded for lack of a buffer. Every later byte of that frame is discarded up to its end marker, and no end-flagged descriptor is written for it. A new start marker begins a fresh attempt.
- R10: Status bits are sticky and are cleared by writing 1 to the matching bit of `stat_clr`; a same-cycle set wins. `irq` is high exactly when any status bit is set.
- R11: While `rx_en` is low, input beats are ignored. A beat without a start marker outside a frame is also ignored. Ignored beats produce no writes and no state change.
- R12: A start marker that arrives inside a frame restarts reception at offset 0 of the current slot. The unfinished bytes of that slot are abandoned without a descriptor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| ring_base | input | 32 | Base address of the descriptor ring |
| buf_base | input | 32 | Base address of the buffer area (128-byte aligned) |
| in_valid | input | 1 | Byte beat valid |
| in_data | input | 8 | Byte value |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| rel_en | input | 1 | Release pulse from software |
| rel_idx | input | 3 | Slot whose ownership bit is cleared |
| stat_clr | input | 3 | Write-one-to-clear for status bits |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Byte address of the buffer write |
| buf_byte | output | 8 | Byte written |
| desc_we | output | 1 | Descriptor write strobe |
| desc_addr | output | 32 | Address of the descriptor's first word |
| desc_addr_word | output | 32 | Address word (buffer address, wrap, owned) |
| desc_ctrl_word | output | 32 | Control word (length, start flag, end flag) |
| status | output | 3 | {overrun, no buffer, frame done} |
| irq | output | 1 | Interrupt, OR of status bits |

## Verification
The assertions check several rules on every cycle:
- A slot is never claimed while it is already owned.
- A byte written to the top address of a slot always comes with a descriptor write.
- A length appears only in an end-flagged control word.
- A dropping frame produces no byte writes.
- A disabled receiver stays silent.
- Status bits stay set until cleared.

Some behaviours need whole scenarios and are shown only by the bench. These are the wrap back to slot 0, the split of long frames across slots with exact lengths, the no-buffer event when the ring fills, the overrun that leaves a start-only fragment, releases that make slots usable again, and the mid-frame restart.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int ST_W        = 3;
    localparam int ST_DONE     = 0;
    localparam int ST_NOBUF    = 1;
    localparam int ST_OVR      = 2;

    localparam int LEN_W       = 11;
    localparam int CTL_SOF_BIT = 14;
    localparam int CTL_EOF_BIT = 15;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       sof;
        logic       eof;
    } rx_beat_t;

    typedef struct packed {
        logic [31:0] addr_word;
        logic [31:0] ctrl_word;
    } desc_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_DROP = 2'd2
    } fstate_e;

    function automatic logic [31:0] mk_addr_word(input logic [31:0] slot_addr,
                                                 input logic        wrap);
        return {slot_addr[31:2], wrap, 1'b1};
    endfunction

    function automatic logic [31:0] mk_ctrl_word(input logic [LEN_W-1:0] len,
                                                 input logic             first,
                                                 input logic             last);
        logic [31:0] w;
        w = '0;
        if (last) w[LEN_W-1:0] = len;
        w[CTL_SOF_BIT] = first;
        w[CTL_EOF_BIT] = last;
        return w;
    endfunction

endpackage

// File: rtl/rxr_own_table.sv
module rxr_own_table #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] look_a,
    input  logic [IDX_W-1:0] look_b,
    output logic             busy_a,
    output logic             busy_b
);

    logic [ENTRIES-1:0] used_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                used_q[g] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(g))
                used_q[g] <= 1'b1;
            else if (clr_en && clr_idx == IDX_W'(g))
                used_q[g] <= 1'b0;
        end
    end

    assign busy_a = used_q[look_a];
    assign busy_b = used_q[look_b];

    // R3: the controller only claims a slot that software has handed back
    a_r3_claim_free: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !used_q[set_idx]);

endmodule

// File: rtl/rxr_status.sv
module rxr_status
    import rxr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_vec,
    input  logic [ST_W-1:0] clr_vec,
    output logic [ST_W-1:0] status,
    output logic            irq
);

    logic [ST_W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    assign status = flags_q;
    assign irq    = |flags_q;

    for (genvar g = 0; g < ST_W; g++) begin : g_chk
        // R10: a raised flag survives until software clears it
        a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
            (flags_q[g] && !clr_vec[g]) |=> flags_q[g]);
    end

endmodule

// File: rtl/rxr_frag_ctl.sv
module rxr_frag_ctl
    import rxr_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int BUF_BYTES = 128,
    parameter int IDX_W     = 3,
    parameter int OFF_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic [31:0]      ring_base,
    input  logic [31:0]      buf_base,
    input  rx_beat_t         beat,
    input  logic             busy_cur,
    input  logic             busy_next,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             claim_en,
    output logic [ST_W-1:0]  st_set,
    output logic             buf_we,
    output logic [31:0]      buf_addr,
    output logic [7:0]       buf_byte,
    output logic             desc_we,
    output logic [31:0]      desc_addr,
    output desc_t            desc
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BUF_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    fstate_e          st_q, st_d, eff_st;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [OFF_W-1:0] off_q, off_d, eff_off;
    logic [LEN_W-1:0] len_q, len_d, eff_len, len_inc;
    logic             first_q, first_d, eff_first;
    logic             accept, starting, starve, take, drop_byte, close;
    logic [31:0]      slot_addr;

    always_comb begin
        accept    = rx_en && beat.valid;
        starting  = accept && beat.sof;
        eff_st    = starting ? FS_FILL : st_q;
        eff_off   = starting ? '0 : off_q;
        eff_len   = starting ? '0 : len_q;
        eff_first = starting ? 1'b1 : first_q;
        starve    = accept && eff_st == FS_FILL && eff_off == '0 && busy_cur;
        take      = accept && eff_st == FS_FILL && !starve;
        drop_byte = accept && eff_st == FS_DROP;
        close     = take && (eff_off == LAST_OFF || beat.eof);
        len_inc   = eff_len + LEN_W'(1);
        nxt_idx   = (cur_q == LAST_IDX) ? '0 : cur_q + IDX_W'(1);
        slot_addr = {buf_base[31:OFF_W], {OFF_W{1'b0}}} + 32'(cur_q) * 32'(BUF_BYTES);
    end

    always_comb begin
        st_d    = st_q;
        cur_d   = cur_q;
        off_d   = off_q;
        len_d   = len_q;
        first_d = first_q;
        if (starting) begin
            st_d    = FS_FILL;
            off_d   = '0;
            len_d   = '0;
            first_d = 1'b1;
        end
        if (starve)
            st_d = FS_DROP;
        if (take) begin
            len_d = len_inc;
            if (close) begin
                off_d   = '0;
                first_d = 1'b0;
                cur_d   = nxt_idx;
            end else begin
                off_d = eff_off + OFF_W'(1);
            end
        end
        if (accept && beat.eof && eff_st != FS_IDLE)
            st_d = FS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FS_IDLE;
            cur_q   <= '0;
            off_q   <= '0;
            len_q   <= '0;
            first_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cur_q   <= cur_d;
            off_q   <= off_d;
            len_q   <= len_d;
            first_q <= first_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_byte  <= '0;
            desc_we   <= 1'b0;
            desc_addr <= '0;
            desc      <= '0;
        end else begin
            buf_we    <= take;
            buf_addr  <= slot_addr + 32'(eff_off);
            buf_byte  <= beat.data;
            desc_we   <= close;
            desc_addr <= ring_base + (32'(cur_q) << 3);
            desc.addr_word <= mk_addr_word(slot_addr, cur_q == LAST_IDX);
            desc.ctrl_word <= mk_ctrl_word(len_inc, eff_first, beat.eof);
        end
    end

    always_comb begin
        st_set            = '0;
        st_set[ST_DONE]   = close && beat.eof;
        st_set[ST_NOBUF]  = starve || (close && busy_next);
        st_set[ST_OVR]    = starve || drop_byte;
    end

    assign cur_idx  = cur_q;
    assign claim_en = close;

    // R2: a byte landing in the top byte of a slot comes with that slot's descriptor
    a_r2_full_closes: assert property (@(posedge clk) disable iff (rst)
        (buf_we && buf_addr[OFF_W-1:0] == LAST_OFF) |-> desc_we);

    // R11: nothing is written in the cycle after reception was disabled
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!buf_we && !desc_we));

    // R6: a length only appears in an end-flagged control word
    a_r6_len_on_last: assert property (@(posedge clk) disable iff (rst)
        (desc_we && !desc.ctrl_word[CTL_EOF_BIT]) |-> desc.ctrl_word[LEN_W-1:0] == '0);

    // R9: while a frame is being discarded and no new start arrives, no byte is stored
    a_r9_drop_silent: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_DROP && !(beat.valid && beat.sof)) |=> !buf_we);

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int RING_ENTRIES = 8,
    parameter int BUF_BYTES    = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic [31:0] ring_base,
    input  logic [31:0] buf_base,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        rel_en,
    input  logic [((RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1)-1:0] rel_idx,
    input  logic [2:0]  stat_clr,
    output logic        buf_we,
    output logic [31:0] buf_addr,
    output logic [7:0]  buf_byte,
    output logic        desc_we,
    output logic [31:0] desc_addr,
    output logic [31:0] desc_addr_word,
    output logic [31:0] desc_ctrl_word,
    output logic [2:0]  status,
    output logic        irq
);

    localparam int IDX_W = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1;
    localparam int OFF_W = $clog2(BUF_BYTES);

    rx_beat_t         beat;
    desc_t            desc;
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic             busy_cur, busy_next, claim_en;
    logic [ST_W-1:0]  st_set;

    assign beat = '{valid: in_valid, data: in_data, sof: in_sof, eof: in_eof};

    rxr_own_table #(.ENTRIES(RING_ENTRIES), .IDX_W(IDX_W)) u_own (
        .clk     (clk),
        .rst     (rst),
        .set_en  (claim_en),
        .set_idx (cur_idx),
        .clr_en  (rel_en),
        .clr_idx (rel_idx),
        .look_a  (cur_idx),
        .look_b  (nxt_idx),
        .busy_a  (busy_cur),
        .busy_b  (busy_next)
    );

    rxr_frag_ctl #(
        .ENTRIES(RING_ENTRIES), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .ring_base (ring_base),
        .buf_base  (buf_base),
        .beat      (beat),
        .busy_cur  (busy_cur),
        .busy_next (busy_next),
        .cur_idx   (cur_idx),
        .nxt_idx   (nxt_idx),
        .claim_en  (claim_en),
        .st_set    (st_set),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_byte  (buf_byte),
        .desc_we   (desc_we),
        .desc_addr (desc_addr),
        .desc      (desc)
    );

    rxr_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (st_set),
        .clr_vec (stat_clr),
        .status  (status),
        .irq     (irq)
    );

    assign desc_addr_word = desc.addr_word;
    assign desc_ctrl_word = desc.ctrl_word;

endmodule

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int BB = 128;

    logic        clk = 1'b0;
    logic        rst, rx_en, in_valid, in_sof, in_eof, rel_en;
    logic [31:0] ring_base, buf_base;
    logic [7:0]  in_data;
    logic [2:0]  rel_idx, stat_clr;
    logic        buf_we, desc_we, irq;
    logic [31:0] buf_addr, desc_addr, desc_addr_word, desc_ctrl_word;
    logic [7:0]  buf_byte;
    logic [2:0]  status;

    rx_ring_writer dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base), .buf_base(buf_base),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .rel_en(rel_en), .rel_idx(rel_idx), .stat_clr(stat_clr),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_byte(buf_byte),
        .desc_we(desc_we), .desc_addr(desc_addr), .desc_addr_word(desc_addr_word),
        .desc_ctrl_word(desc_ctrl_word), .status(status), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int       m_mode;   // 0 idle, 1 filling, 2 dropping
    int       m_cur, m_off, m_len;
    bit       m_first;
    bit       m_used[N];
    bit [2:0] m_stat;

    // expected outputs after the next edge
    bit          e_bwe, e_dwe;
    logic [31:0] e_baddr, e_daddr, e_aw, e_cw;
    logic [7:0]  e_bbyte;

    // observations for scenario checks
    int          desc_seen = 0;
    logic [31:0] last_aw, last_cw, last_daddr;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_cur = 0; m_off = 0; m_len = 0; m_first = 0; m_stat = '0;
        for (int i = 0; i < N; i++) m_used[i] = 0;
        e_bwe = 0; e_dwe = 0;
    endtask

    task automatic model_step();
        bit acc, strt, starve, take, dropb, close, efirst;
        int emode, eoff, elen, nxt;
        logic [31:0] slot;
        logic [2:0]  setv;
        acc    = rx_en && in_valid;
        strt   = acc && in_sof;
        emode  = strt ? 1 : m_mode;
        eoff   = strt ? 0 : m_off;
        elen   = strt ? 0 : m_len;
        efirst = strt ? 1 : m_first;
        starve = acc && emode == 1 && eoff == 0 && m_used[m_cur];
        take   = acc && emode == 1 && !starve;
        dropb  = acc && emode == 2;
        close  = take && (eoff == BB - 1 || in_eof);
        nxt    = (m_cur + 1) % N;
        slot   = {buf_base[31:7], 7'b0} + 32'(m_cur * BB);

        e_bwe   = take;
        e_baddr = slot + 32'(eoff);
        e_bbyte = in_data;
        e_dwe   = close;
        e_daddr = ring_base + 32'(m_cur * 8);
        e_aw    = slot | ((m_cur == N - 1) ? 32'h2 : 32'h0) | 32'h1;
        e_cw    = (in_eof ? 32'((elen + 1) % 2048) : 32'h0)
                | (efirst ? 32'h4000 : 32'h0) | (in_eof ? 32'h8000 : 32'h0);

        setv    = {starve || dropb, starve || (close && m_used[nxt]), close && in_eof};
        m_stat  = (m_stat & ~stat_clr) | setv;

        if (acc) begin
            if (strt) begin m_mode = 1; m_off = 0; m_len = 0; m_first = 1; end
            if (starve) m_mode = 2;
            if (take) begin
                m_len = elen + 1;
                if (close) begin m_off = 0; m_first = 0; end
                else m_off = eoff + 1;
            end
            if (in_eof && emode != 0) m_mode = 0;
        end
        if (rel_en) m_used[rel_idx] = 0;
        if (close) begin m_used[m_cur] = 1; m_cur = nxt; end
    endtask

    task automatic compare();
        check("R1/R11 byte write strobe", 32'(buf_we), 32'(e_bwe));
        if (e_bwe) begin
            check("R1 byte address", buf_addr, e_baddr);
            check("R1 byte value", 32'(buf_byte), 32'(e_bbyte));
        end
        check("R2 descriptor strobe", 32'(desc_we), 32'(e_dwe));
        if (e_dwe) begin
            check("R2 descriptor address", desc_addr, e_daddr);
            check("R3/R4 address word", desc_addr_word, e_aw);
            check("R5/R6 control word", desc_ctrl_word, e_cw);
        end
        check("R7/R8/R9 status flags", 32'(status), 32'(m_stat));
        check("R10 irq", 32'(irq), 32'(|m_stat));
        if (desc_we) begin
            desc_seen++;
            last_aw = desc_addr_word; last_cw = desc_ctrl_word; last_daddr = desc_addr;
        end
    endtask

    task automatic cyc(input bit v, input logic [7:0] d, input bit s, input bit e);
        @(negedge clk);
        in_valid = v; in_data = d; in_sof = s; in_eof = e;
        model_step();
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare();
        rel_en = 0; stat_clr = '0;
    endtask

    task automatic send_frame(input int len, input int seed);
        for (int i = 0; i < len; i++)
            cyc(1, 8'(seed + i), i == 0, i == len - 1);
        cyc(0, 8'h00, 0, 0);
    endtask

    task automatic release_slot(input int idx);
        rel_en = 1; rel_idx = 3'(idx);
        cyc(0, 8'h00, 0, 0);
    endtask

    task automatic clear_status();
        stat_clr = 3'b111;
        cyc(0, 8'h00, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        int base_cnt;
        rst = 1; rx_en = 0; in_valid = 0; in_data = 0; in_sof = 0; in_eof = 0;
        rel_en = 0; rel_idx = 0; stat_clr = 0;
        ring_base = 32'h0000_1000; buf_base = 32'h0002_0000;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #(CLK_PERIOD/4);
        check("R2 reset descriptor strobe", 32'(desc_we), 0);
        check("R1 reset byte strobe", 32'(buf_we), 0);
        check("R10 reset status", 32'(status), 0);
        check("R10 reset irq", 32'(irq), 0);

        rx_en = 1;
        // short frame in slot 0
        send_frame(5, 8'h10);
        check("R5 R6 short frame control", last_cw, 32'h0000_C005);
        check("R7 done flag", 32'(status[0]), 1);
        clear_status();

        // 300-byte frame over slots 1..3
        base_cnt = desc_seen;
        send_frame(300, 8'h40);
        check("R2 three fragments", 32'(desc_seen - base_cnt), 3);
        check("R6 long frame length", last_cw, 32'h0000_812C);

        // exactly one full slot
        send_frame(128, 8'h80);
        check("R2 R5 R6 full-slot frame", last_cw, 32'h0000_C080);

        // disabled receiver and stray bytes
        base_cnt = desc_seen;
        rx_en = 0;
        send_frame(10, 8'hA0);
        rx_en = 1;
        for (int i = 0; i < 5; i++) cyc(1, 8'(i), 0, i == 4);
        check("R11 ignored beats", 32'(desc_seen - base_cnt), 0);

        // restart mid-frame in slot 5
        for (int i = 0; i < 20; i++) cyc(1, 8'(i), i == 0, 0);
        send_frame(6, 8'hC0);
        check("R12 restart descriptor address", last_daddr, 32'h0000_1028);
        check("R12 restart length", last_cw, 32'h0000_C006);
        clear_status();

        // slots 6 and 7, then ring full
        send_frame(2, 8'h01);
        send_frame(2, 8'h02);
        check("R4 wrap bit on last slot", 32'(last_aw[1:0]), 32'h3);
        check("R8 no-buffer on advance", 32'(status[1]), 1);

        // starved frame
        base_cnt = desc_seen;
        send_frame(4, 8'h03);
        check("R9 overrun flag", 32'(status[2]), 1);
        check("R9 no descriptor for dropped frame", 32'(desc_seen - base_cnt), 0);
        clear_status();

        // hand back slots 0 and 1, frame wraps to slot 0
        release_slot(0);
        release_slot(1);
        send_frame(200, 8'h20);
        check("R3 R4 reuse after wrap", last_daddr, 32'h0000_1008);
        check("R6 wrapped frame length", last_cw, 32'h0000_80C8);
        clear_status();

        // only slot 2 free: frame runs out mid-way
        release_slot(2);
        send_frame(200, 8'h55);
        check("R9 start-only fragment", last_cw, 32'h0000_4000);
        check("R9 overrun mid-frame", 32'(status[2]), 1);
        clear_status();

        // free everything, move the ring, next slot is 3
        for (int i = 0; i < N; i++) release_slot(i);
        ring_base = 32'h0000_3000;
        send_frame(3, 8'h77);
        check("R2 moved ring address", last_daddr, 32'h0000_3018);

        repeat (2) cyc(0, 8'h00, 0, 0);
        finish_sim();
    end

endmodule